// File: doc/BRIEF.md
# Interrupt-Acknowledge Bus Select Controller

This block follows the processor's two-cycle interrupt-acknowledge sequence and decides which bus answers the second cycle, the one that reads the 8-bit vector. In the first cycle, the master interrupt controller places a 3-bit active-low cascade code on its outputs to name a slave controller. That code needs time to settle and be decoded. The block holds its ready output low for a computed number of wait states, so that bus select is valid before the second cycle. The wait count is derived from the clock period, the settle and decode budget (565 ns plus 30 ns), and the idle clocks the processor always inserts between the two cycles.

At the end of the wait period, the block samples the cascade code and looks it up in an 8-bit remote map, one bit per code. A set bit sends that slave's vector read to the remote system bus. When the remote bus is chosen, the block raises the bus select and the arbiter enable. It also opens a short cascade-enable window at the start of the second cycle, so the code can be driven onto address bits A8 to A10 and latched on the remote bus. The window closes after a fixed count, or earlier if the cycle ends first, so it is gone before the processor drives the address bus again.

A build option can remove the decode and tie every acknowledge to one bus. This covers systems where the master and all slaves sit on the same side.

Top module: `intack_bus_select`

## Requirements
- R1: With the default 20 ns clock and 4 idle clocks, the first-cycle wait count is ceil(595 ns / Tclk) - 4 = 26. If an acknowledge start is sampled at clock edge k, `first_rdy` stays low until edge k+26 and is high in the cycle that follows that edge.
- R2: When the idle clocks already cover the 595 ns budget, the wait count floors at zero. `first_rdy` is then high in the cycle right after the start edge.
- R3: `first_rdy` is a single-cycle pulse and is never high while `cas_oe` is high.
- R4: The cascade code is sampled on the clock edge at which `first_rdy` is high. Later changes to `cas_n` do not alter the decision for the current sequence.
- R5: In decode mode, the sampled code is c = ~cas_n (active low). `bus_sel_remote` becomes `remote_map[c]` one cycle after the sampling edge.
- R6: `arb_en` is high from the cycle after sampling until the second cycle ends, only when the decision is remote. It is never high without `bus_sel_remote`.
- R7: For a remote decision, `cas_oe` goes high in the cycle after the second acknowledge start is sampled and stays high for CE_CLKS = 3 cycles. For a local decision it stays low.
- R8: `vec_done` ends the second cycle. `cas_oe` is low in the cycle after `vec_done` is sampled, even if its window has not run out.
- R9: After the second cycle ends, `bus_sel_remote` and `arb_en` return to 0 in decode mode.
- R10: A non-acknowledge bus cycle start between the two acknowledge cycles abandons the sequence and clears `arb_en` and `bus_sel_remote`. The next acknowledge start is then treated as a first cycle, with full wait states.
- R11: In the all-remote build, `bus_sel_remote` is constantly 1 and `arb_en` follows the sequence from sampling to end.
- R12: After reset, `first_rdy`, `arb_en`, `cas_oe` and (decode mode) `bus_sel_remote` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | A processor bus cycle begins (one-clock strobe) |
| cyc_inta | input | 1 | Qualifies `cyc_start` as an interrupt-acknowledge cycle |
| vec_done | input | 1 | The second (vector-read) cycle has completed |
| cas_n | input | 3 | Active-low cascade code from the master controller |
| remote_map | input | 8 | Bit c set: cascade code c lives on the remote bus |
| first_rdy | output | 1 | Ready for the first acknowledge cycle after its wait states |
| bus_sel_remote | output | 1 | 1 selects the remote bus for the vector read |
| arb_en | output | 1 | Enables the remote bus arbiter |
| cas_oe | output | 1 | Cascade enable gating the code onto A8-A10 |

## Verification
The assertions rely on two input conditions. First, `vec_done` is raised only during a second acknowledge cycle. Second, no bus cycle starts during the first cycle's wait period, since the processor is stalled on `first_rdy`. The stimulus follows the real protocol to meet both: it issues a start only when the sequence expects one and pulses `vec_done` only after the second start. Stray starts are injected only between the two acknowledge cycles. The sweep covers every cascade code under two complementary maps. It changes `cas_n` both before and after the sampling edge.

// File: rtl/ibs_pkg.sv
package ibs_pkg;

   localparam int SEL_DECODE     = 0;
   localparam int SEL_ALL_LOCAL  = 1;
   localparam int SEL_ALL_REMOTE = 2;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_WAIT   = 2'd1,
      PH_ARMED  = 2'd2,
      PH_SECOND = 2'd3
   } ack_phase_e;

   // clocks to stretch the first acknowledge cycle, floored at zero
   function automatic int wait_states(input int clk_ps, input int settle_ps,
                                      input int decode_ps, input int idle_clks);
      int need;
      need = (settle_ps + decode_ps + clk_ps - 1) / clk_ps;
      return (need > idle_clks) ? (need - idle_clks) : 0;
   endfunction

endpackage

// File: rtl/ibs_phase_seq.sv
module ibs_phase_seq
   import ibs_pkg::*;
#(
   parameter int WAIT_CLKS = 26,
   parameter int CNT_W     = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_start,
   input  logic       cyc_inta,
   input  logic       vec_done,
   output ack_phase_e phase,
   output logic       first_rdy,
   output logic       second_begin,
   output logic       seq_end
);

   logic [CNT_W-1:0] wait_cnt;
   logic             inta_start;
   logic             stray_start;

   assign inta_start   = cyc_start && cyc_inta;
   assign stray_start  = cyc_start && !cyc_inta;
   assign first_rdy    = (phase == PH_WAIT) && (wait_cnt == '0);
   assign second_begin = (phase == PH_ARMED) && inta_start;
   assign seq_end      = ((phase == PH_SECOND) && vec_done) ||
                         ((phase == PH_ARMED) && stray_start);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         wait_cnt <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (inta_start) begin
                  phase    <= PH_WAIT;
                  wait_cnt <= CNT_W'(WAIT_CLKS);
               end
            end
            PH_WAIT: begin
               if (wait_cnt == '0) phase <= PH_ARMED;
               else                wait_cnt <= wait_cnt - CNT_W'(1);
            end
            PH_ARMED: begin
               if (inta_start)       phase <= PH_SECOND;
               else if (stray_start) phase <= PH_IDLE;
            end
            PH_SECOND: begin
               if (vec_done) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ibs_cas_decode.sv
module ibs_cas_decode
   import ibs_pkg::*;
#(
   parameter int SEL_MODE = SEL_DECODE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture_now,
   input  logic       seq_end,
   input  logic [2:0] cas_n,
   input  logic [7:0] remote_map,
   output logic       remote_q,
   output logic       bus_sel
);

   generate
      if (SEL_MODE == SEL_DECODE) begin : g_decode
         logic hit;
         assign hit = remote_map[~cas_n];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           remote_q <= 1'b0;
            else if (capture_now) remote_q <= hit;
            else if (seq_end)     remote_q <= 1'b0;
         end
         assign bus_sel = remote_q;
      end else if (SEL_MODE == SEL_ALL_REMOTE) begin : g_remote
         logic unused_dec;
         assign unused_dec = ^{clk, rst_n, capture_now, seq_end, cas_n, remote_map};
         assign remote_q   = 1'b1;
         assign bus_sel    = 1'b1;
      end else begin : g_local
         logic unused_dec;
         assign unused_dec = ^{clk, rst_n, capture_now, seq_end, cas_n, remote_map};
         assign remote_q   = 1'b0;
         assign bus_sel    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/ibs_cas_timer.sv
module ibs_cas_timer #(
   parameter int CE_CLKS = 3,
   parameter int TW      = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic second_begin,
   input  logic seq_end,
   input  logic remote_q,
   output logic cas_oe
);

   logic [TW-1:0] win_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              win_cnt <= '0;
      else if (second_begin)   win_cnt <= TW'(CE_CLKS);
      else if (seq_end)        win_cnt <= '0;
      else if (win_cnt != '0)  win_cnt <= win_cnt - TW'(1);
   end

   assign cas_oe = (win_cnt != '0) && remote_q;

endmodule

// File: rtl/intack_bus_select.sv
module intack_bus_select
   import ibs_pkg::*;
#(
   parameter int CLK_PS    = 20000,
   parameter int SETTLE_PS = 565000,
   parameter int DECODE_PS = 30000,
   parameter int IDLE_CLKS = 4,
   parameter int CE_CLKS   = 3,
   parameter int SEL_MODE  = SEL_DECODE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_start,
   input  logic       cyc_inta,
   input  logic       vec_done,
   input  logic [2:0] cas_n,
   input  logic [7:0] remote_map,
   output logic       first_rdy,
   output logic       bus_sel_remote,
   output logic       arb_en,
   output logic       cas_oe
);

   localparam int WAIT_CLKS = wait_states(CLK_PS, SETTLE_PS, DECODE_PS, IDLE_CLKS);
   localparam int CNT_W     = (WAIT_CLKS > 0) ? $clog2(WAIT_CLKS + 1) : 1;
   localparam int TW        = $clog2(CE_CLKS + 1);

   generate
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
      if (CE_CLKS < 1) begin : g_bad_ce
         $error("CE_CLKS must be at least one");
      end
      if (SEL_MODE < SEL_DECODE || SEL_MODE > SEL_ALL_REMOTE) begin : g_bad_mode
         $error("SEL_MODE out of range");
      end
   endgenerate

   ack_phase_e phase;
   logic       second_begin;
   logic       seq_end;
   logic       remote_q;
   logic       in_seq;

   ibs_phase_seq #(
      .WAIT_CLKS (WAIT_CLKS),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cyc_start    (cyc_start),
      .cyc_inta     (cyc_inta),
      .vec_done     (vec_done),
      .phase        (phase),
      .first_rdy    (first_rdy),
      .second_begin (second_begin),
      .seq_end      (seq_end)
   );

   ibs_cas_decode #(
      .SEL_MODE (SEL_MODE)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_now (first_rdy),
      .seq_end     (seq_end),
      .cas_n       (cas_n),
      .remote_map  (remote_map),
      .remote_q    (remote_q),
      .bus_sel     (bus_sel_remote)
   );

   ibs_cas_timer #(
      .CE_CLKS (CE_CLKS),
      .TW      (TW)
   ) u_tmr (
      .clk          (clk),
      .rst_n        (rst_n),
      .second_begin (second_begin),
      .seq_end      (seq_end),
      .remote_q     (remote_q),
      .cas_oe       (cas_oe)
   );

   assign in_seq = (phase == PH_ARMED) || (phase == PH_SECOND);
   assign arb_en = in_seq && remote_q;

endmodule

// File: rtl/ibs_ack_sel_chk.sv
module ibs_ack_sel_chk #(
   parameter int CE_CLKS = 3
) (
   input logic clk,
   input logic rst_n,
   input logic cyc_start,
   input logic cyc_inta,
   input logic vec_done,
   input logic first_rdy,
   input logic bus_sel_remote,
   input logic arb_en,
   input logic cas_oe
);

   int unsigned oe_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      oe_run <= 0;
      else if (cas_oe) oe_run <= oe_run + 1;
      else             oe_run <= 0;
   end

   a_r3_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      first_rdy |=> !first_rdy);

   a_r3_rdy_not_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      cas_oe |-> !first_rdy);

   a_r6_arb_needs_remote: assert property (@(posedge clk) disable iff (!rst_n)
      arb_en |-> bus_sel_remote);

   a_r7_cas_needs_arb: assert property (@(posedge clk) disable iff (!rst_n)
      cas_oe |-> arb_en);

   a_r7_cas_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_oe) |-> $past(cyc_start && cyc_inta));

   a_r7_cas_window: assert property (@(posedge clk) disable iff (!rst_n)
      cas_oe |-> (oe_run < CE_CLKS));

   a_r8_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
      vec_done |=> !cas_oe);

   a_r10_stray_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !cyc_inta && !cas_oe) |=> !arb_en);

endmodule

bind intack_bus_select ibs_ack_sel_chk #(.CE_CLKS(CE_CLKS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cyc_start      (cyc_start),
   .cyc_inta       (cyc_inta),
   .vec_done       (vec_done),
   .first_rdy      (first_rdy),
   .bus_sel_remote (bus_sel_remote),
   .arb_en         (arb_en),
   .cas_oe         (cas_oe)
);

// File: tb/intack_bus_select_tb.sv
module intack_bus_select_tb;

   localparam int CLK_PS  = 20000;
   localparam int CE_CLKS = 3;
   // ceil(595 ns / 20 ns) = 30, minus 4 idle clocks
   localparam int NW      = ((565000 + 30000) + CLK_PS - 1) / CLK_PS - 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0;
   logic       cyc_inta = 1'b0;
   logic       vec_done = 1'b0;
   logic [2:0] cas_n = 3'b111;
   logic [7:0] remote_map = 8'h00;
   logic       first_rdy, bus_sel_remote, arb_en, cas_oe;
   logic       fx_rdy, fx_sel, fx_arb, fx_oe;

   int checks = 0;
   int errors = 0;

   always #10ns clk = ~clk;

   intack_bus_select #(.CLK_PS(CLK_PS), .CE_CLKS(CE_CLKS), .SEL_MODE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_inta(cyc_inta),
      .vec_done(vec_done), .cas_n(cas_n), .remote_map(remote_map),
      .first_rdy(first_rdy), .bus_sel_remote(bus_sel_remote),
      .arb_en(arb_en), .cas_oe(cas_oe));

   // slow-clock, all-remote build: wait count floors at zero
   intack_bus_select #(.CLK_PS(200000), .CE_CLKS(CE_CLKS), .SEL_MODE(2)) u_fix (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_inta(cyc_inta),
      .vec_done(vec_done), .cas_n(cas_n), .remote_map(remote_map),
      .first_rdy(fx_rdy), .bus_sel_remote(fx_sel),
      .arb_en(fx_arb), .cas_oe(fx_oe));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_seq(input logic [7:0] map, input int code, input bit trunc);
      int  bad;
      bit  exp;
      exp        = map[code];
      remote_map = map;
      cas_n      = ~(3'(code) ^ 3'd5);
      @(negedge clk); cyc_start = 1'b1; cyc_inta = 1'b1;
      @(negedge clk); cyc_start = 1'b0; cyc_inta = 1'b0;
      chk("R2 floor-zero ready", int'(fx_rdy), 1);
      bad = 0;
      for (int j = 0; j < NW; j++) begin
         if (first_rdy) bad++;
         @(negedge clk);
      end
      chk("R1 ready low during waits", bad, 0);
      chk("R1 ready at end of waits", int'(first_rdy), 1);
      cas_n = ~3'(code);
      @(negedge clk);
      cas_n = ~(3'(code) ^ 3'd5);
      chk("R3 ready single pulse", int'(first_rdy), 0);
      chk("R5 decoded select", int'(bus_sel_remote), int'(exp));
      chk("R6 arbiter enable", int'(arb_en), int'(exp));
      chk("R11 fixed remote select", int'(fx_sel), 1);
      chk("R11 fixed remote arbiter", int'(fx_arb), 1);
      @(negedge clk);
      chk("R4 decision held", int'(bus_sel_remote), int'(exp));
      chk("R7 no enable before second", int'(cas_oe), 0);
      cyc_start = 1'b1; cyc_inta = 1'b1;
      @(negedge clk); cyc_start = 1'b0; cyc_inta = 1'b0;
      if (trunc) begin
         chk("R8 window opened", int'(cas_oe), int'(exp));
         vec_done = 1'b1;
         @(negedge clk); vec_done = 1'b0;
         chk("R8 window cut by done", int'(cas_oe), 0);
      end else begin
         bad = 0;
         for (int j = 0; j < CE_CLKS; j++) begin
            if (cas_oe != exp) bad++;
            @(negedge clk);
         end
         chk("R7 window width", bad, 0);
         chk("R7 window closed", int'(cas_oe), 0);
         chk("R6 arbiter through second", int'(arb_en), int'(exp));
         vec_done = 1'b1;
         @(negedge clk); vec_done = 1'b0;
      end
      chk("R9 select released", int'(bus_sel_remote), 0);
      chk("R9 arbiter released", int'(arb_en), 0);
      chk("R11 fixed arbiter released", int'(fx_arb), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset ready", int'(first_rdy), 0);
      chk("R12 reset select", int'(bus_sel_remote), 0);
      chk("R12 reset arbiter", int'(arb_en), 0);
      chk("R12 reset enable", int'(cas_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int c = 0; c < 8; c++) run_seq(8'hA5, c, 1'b0);
      for (int c = 0; c < 8; c++) run_seq(8'h5A, c, 1'b0);
      run_seq(8'hFF, 3, 1'b1);
      run_seq(8'h00, 6, 1'b1);

      // stray non-acknowledge cycle between the two acknowledge cycles
      remote_map = 8'hFF;
      cas_n      = 3'b111;
      @(negedge clk); cyc_start = 1'b1; cyc_inta = 1'b1;
      @(negedge clk); cyc_start = 1'b0; cyc_inta = 1'b0;
      while (!first_rdy) @(negedge clk);
      @(negedge clk);
      chk("R10 armed before stray", int'(arb_en), 1);
      cyc_start = 1'b1; cyc_inta = 1'b0;
      @(negedge clk); cyc_start = 1'b0;
      chk("R10 stray clears arbiter", int'(arb_en), 0);
      chk("R10 stray clears select", int'(bus_sel_remote), 0);
      run_seq(8'h81, 7, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule